// File: doc/BRIEF.md
# DDR2 Extended Mode Shadow and Command Guard

This block sits on the controller side of a DDR2 memory channel. It keeps its own copy of the memory's extended mode register, decodes the fields that the rest of the controller needs, and applies the device's mode-dependent timing rules. It gates READ commands and the on-die-termination pin so that the controller cannot break those rules.

The upstream scheduler presents one command per cycle: a load of the extended mode register, a DLL reset, a READ, self-refresh entry, self-refresh exit, or no operation. It also drives the termination level it would like to see on the pin. The guard answers with a READ-permitted flag and with one-cycle pulses that report each READ as either issued or refused. It also drives the gated termination pin and a set of decoded mode flags. After a DLL reset or a self-refresh exit, READ stays blocked for a fixed lock period. After a mode write that turns termination on, the pin stays low for a fixed settling period. During self refresh, or while termination is off, the pin is held low.

Top module: `ddr2_emr_guard`

## Requirements
- R1: Out of reset, `read_ok`, `odt_pin`, `read_issue`, `read_violation`, `drive_reduced`, `rdqs_n_en` are 0, `rtt_code` is 0 (termination off), and `out_enable` and `dqs_n_en` are 1. The DLL counts as disabled until a mode write sets operand bit 0 to 0.
- R2: After a mode load, the flags follow operand bits on the next cycle: `out_enable` = NOT bit 12; `drive_reduced` = bit 1; `dqs_n_en` = NOT bit 10; `rdqs_n_en` = bit 11 AND NOT bit 10.
- R3: After a mode load, `rtt_code` = {bit 6, bit 2}, with the meanings 00 = off, 01 = 75 ohm, 10 = 150 ohm, 11 = 50 ohm.
- R4: Operand bit 0 = 0 enables the DLL. A DLL reset command (op 2) sampled at edge k, with the DLL enabled and outside self refresh, drops `read_ok`. `read_ok` is then low after edges k through k+LOCK_CYCLES-1 and high after edge k+LOCK_CYCLES. A DLL reset with the DLL disabled or during self refresh has no effect.
- R5: A READ (op 3) sampled while `read_ok` is 1 gives a one-cycle `read_issue` pulse after that edge. A READ sampled while `read_ok` is 0 gives a one-cycle `read_violation` pulse instead, and no issue pulse.
- R6: A mode load (op 1) with operand bit 0 = 1 disables the DLL and clears `read_ok` after that edge.
- R7: Self-refresh entry (op 4) clears `read_ok` and `odt_pin` after that edge. Self-refresh exit (op 5) with the DLL enabled restarts the full lock period of R4, counted from the exit edge.
- R8: A mode load whose operand has {bit 6, bit 2} non-zero, sampled at edge k, keeps `odt_pin` low after edges k through k+ODT_WAIT-1. From edge k+ODT_WAIT on, `odt_pin` follows `odt_req` with one register of delay.
- R9: While `rtt_code` is 0 (termination off) or the memory is in self refresh, `odt_pin` stays 0 whatever `odt_req` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 0 NOP, 1 mode load, 2 DLL reset, 3 READ, 4 self-refresh entry, 5 self-refresh exit |
| cmd_operand | input | 14 | Mode operand for a mode load |
| odt_req | input | 1 | Termination level requested by the scheduler |
| read_ok | output | 1 | READ is permitted this cycle |
| read_issue | output | 1 | Pulse: the last READ was issued |
| read_violation | output | 1 | Pulse: the last READ was refused |
| odt_pin | output | 1 | Gated termination pin level |
| out_enable | output | 1 | Data and strobe outputs active |
| drive_reduced | output | 1 | Reduced output drive selected |
| rtt_code | output | 2 | Termination code |
| dqs_n_en | output | 1 | Complement strobe active |
| rdqs_n_en | output | 1 | Complement read strobe active |

## Verification
The bench measures the lock window to the exact edge, both after a DLL reset and after self-refresh exit. A counter that is off by one would open READ a cycle early or late. A design that forgot to restart the count on exit would allow READ at once. The termination settling window is timed the same way, so a pin that rises one clock early is caught. The bench also sends DLL reset commands that must be ignored: one before the DLL is enabled and one after it has been disabled. A guard that started counting anyway would raise `read_ok` after the lock period. Every READ outcome goes through a scoreboard, so a refused READ that also gives an issue pulse, or no pulse at all, is reported.

// File: rtl/ddr2_emr_guard_pkg.sv
package ddr2_emr_guard_pkg;

  localparam int MODE_W = 14;

  // operand bit positions, fixed by the memory's mode decode
  localparam int BIT_DLL_OFF   = 0;
  localparam int BIT_DRV_HALF  = 1;
  localparam int BIT_TERM_LO   = 2;
  localparam int BIT_TERM_HI   = 6;
  localparam int BIT_STROBE_SE = 10;
  localparam int BIT_RSTROBE   = 11;
  localparam int BIT_OUT_OFF   = 12;

  // DLL disabled, all else default
  localparam logic [MODE_W-1:0] MODE_RESET = MODE_W'(1);

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_LOAD_EMR  = 3'd1,
    OP_DLL_RESET = 3'd2,
    OP_READ      = 3'd3,
    OP_SR_ENTER  = 3'd4,
    OP_SR_EXIT   = 3'd5
  } cmd_op_e;

  typedef enum logic [1:0] {
    TERM_OFF = 2'd0,
    TERM_75  = 2'd1,
    TERM_150 = 2'd2,
    TERM_50  = 2'd3
  } term_e;

endpackage

// File: rtl/emr_shadow.sv
module emr_shadow
  import ddr2_emr_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              dll_on_o,
  output term_e             term_o,
  output logic              out_en_o,
  output logic              drv_half_o,
  output logic              strobe_n_en_o,
  output logic              rstrobe_n_en_o
);

  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= MODE_RESET;
    else if (load_i) mode_q <= mode_i;
  end

  always_comb begin
    dll_on_o       = ~mode_q[BIT_DLL_OFF];
    term_o         = term_e'({mode_q[BIT_TERM_HI], mode_q[BIT_TERM_LO]});
    out_en_o       = ~mode_q[BIT_OUT_OFF];
    drv_half_o     = mode_q[BIT_DRV_HALF];
    strobe_n_en_o  = ~mode_q[BIT_STROBE_SE];
    rstrobe_n_en_o = mode_q[BIT_RSTROBE] & ~mode_q[BIT_STROBE_SE];
  end

endmodule

// File: rtl/dll_lock_timer.sv
module dll_lock_timer #(
  parameter int LOCK_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic abort_i,
  output logic ready_o
);

  localparam int CW = $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      cnt_q   <= '0;
      ready_o <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= CW'(LOCK_CYCLES);
      ready_o <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) ready_o <= 1'b1;
    end
  end

endmodule

// File: rtl/odt_gate.sv
module odt_gate #(
  parameter int WAIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic allow_i,
  input  logic req_i,
  output logic pin_o
);

  localparam int HW = $clog2(WAIT_CYCLES + 1);

  logic [HW-1:0] hold_q;
  logic [HW-1:0] hold_d;

  always_comb begin
    if (arm_i)              hold_d = HW'(WAIT_CYCLES);
    else if (hold_q != '0)  hold_d = hold_q - HW'(1);
    else                    hold_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      pin_o  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      pin_o  <= req_i & allow_i & (hold_d == '0);
    end
  end

endmodule

// File: rtl/ddr2_emr_guard.sv
module ddr2_emr_guard
  import ddr2_emr_guard_pkg::*;
#(
  parameter int LOCK_CYCLES = 200,
  parameter int ODT_WAIT    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [MODE_W-1:0] cmd_operand,
  input  logic              odt_req,
  output logic              read_ok,
  output logic              read_issue,
  output logic              read_violation,
  output logic              odt_pin,
  output logic              out_enable,
  output logic              drive_reduced,
  output logic [1:0]        rtt_code,
  output logic              dqs_n_en,
  output logic              rdqs_n_en
);

  cmd_op_e op;
  logic    is_load, is_dll_rst, is_read, is_sr_in, is_sr_out;
  logic    dll_on, sr_q, sr_d, term_on_d, lock_start, lock_abort;
  term_e   term;

  always_comb begin
    op         = cmd_op_e'(cmd_op);
    is_load    = cmd_valid && op == OP_LOAD_EMR;
    is_dll_rst = cmd_valid && op == OP_DLL_RESET;
    is_read    = cmd_valid && op == OP_READ;
    is_sr_in   = cmd_valid && op == OP_SR_ENTER;
    is_sr_out  = cmd_valid && op == OP_SR_EXIT;
  end

  emr_shadow u_shadow (
    .clk            (clk),
    .rst            (rst),
    .load_i         (is_load),
    .mode_i         (cmd_operand),
    .dll_on_o       (dll_on),
    .term_o         (term),
    .out_en_o       (out_enable),
    .drv_half_o     (drive_reduced),
    .strobe_n_en_o  (dqs_n_en),
    .rstrobe_n_en_o (rdqs_n_en)
  );

  assign rtt_code = term;

  // self-refresh state
  always_comb begin
    if (is_sr_in)       sr_d = 1'b1;
    else if (is_sr_out) sr_d = 1'b0;
    else                sr_d = sr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) sr_q <= 1'b0;
    else     sr_q <= sr_d;
  end

  // DLL lock window
  assign lock_start = (is_dll_rst && dll_on && !sr_q) ||
                      (is_sr_out && sr_q && dll_on);
  assign lock_abort = (is_load && cmd_operand[BIT_DLL_OFF]) || is_sr_in;

  dll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk     (clk),
    .rst     (rst),
    .start_i (lock_start),
    .abort_i (lock_abort),
    .ready_o (read_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      read_issue     <= 1'b0;
      read_violation <= 1'b0;
    end else begin
      read_issue     <= is_read && read_ok;
      read_violation <= is_read && !read_ok;
    end
  end

  // termination gating
  assign term_on_d = is_load ? ({cmd_operand[BIT_TERM_HI], cmd_operand[BIT_TERM_LO]} != 2'b00)
                             : (term != TERM_OFF);

  odt_gate #(.WAIT_CYCLES(ODT_WAIT)) u_odt (
    .clk     (clk),
    .rst     (rst),
    .arm_i   (is_load && term_on_d),
    .allow_i (term_on_d && !sr_d),
    .req_i   (odt_req),
    .pin_o   (odt_pin)
  );

endmodule

// File: rtl/ddr2_emr_guard_chk.sv
module ddr2_emr_guard_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic        read_ok,
  input logic        read_issue,
  input logic        read_violation,
  input logic        odt_pin,
  input logic [1:0]  rtt_code,
  input logic        dqs_n_en,
  input logic        rdqs_n_en
);

  // R5
  read_pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({read_issue, read_violation}));

  // R5
  violation_src_chk: assert property (@(posedge clk) disable iff (rst)
    read_violation |-> $past(cmd_valid && cmd_op == 3'd3 && !read_ok));

  // R5
  issue_src_chk: assert property (@(posedge clk) disable iff (rst)
    read_issue |-> $past(cmd_valid && cmd_op == 3'd3 && read_ok));

  // R4
  dll_reset_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd2 && read_ok) |=> !read_ok);

  // R7
  sr_entry_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd4) |=> (!odt_pin && !read_ok));

  // R9
  odt_needs_term_chk: assert property (@(posedge clk) disable iff (rst)
    odt_pin |-> rtt_code != 2'b00);

  // R8
  odt_load_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd1) |=> !odt_pin);

  // R2
  rstrobe_pair_chk: assert property (@(posedge clk) disable iff (rst)
    rdqs_n_en |-> dqs_n_en);

endmodule

bind ddr2_emr_guard ddr2_emr_guard_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .cmd_valid      (cmd_valid),
  .cmd_op         (cmd_op),
  .read_ok        (read_ok),
  .read_issue     (read_issue),
  .read_violation (read_violation),
  .odt_pin        (odt_pin),
  .rtt_code       (rtt_code),
  .dqs_n_en       (dqs_n_en),
  .rdqs_n_en      (rdqs_n_en)
);

// File: tb/tb_ddr2_emr_guard.sv
`timescale 1ns/1ps
module tb_ddr2_emr_guard;
  import ddr2_emr_guard_pkg::*;

  localparam int LOCK  = 200;
  localparam int OWAIT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [13:0] cmd_operand = '0;
  logic        odt_req = 1'b0;
  logic        read_ok, read_issue, read_violation, odt_pin;
  logic        out_enable, drive_reduced, dqs_n_en, rdqs_n_en;
  logic [1:0]  rtt_code;

  always #2.5 clk = ~clk;

  ddr2_emr_guard #(.LOCK_CYCLES(LOCK), .ODT_WAIT(OWAIT)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_operand(cmd_operand), .odt_req(odt_req), .read_ok(read_ok),
    .read_issue(read_issue), .read_violation(read_violation), .odt_pin(odt_pin),
    .out_enable(out_enable), .drive_reduced(drive_reduced), .rtt_code(rtt_code),
    .dqs_n_en(dqs_n_en), .rdqs_n_en(rdqs_n_en)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;
  bit exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input cmd_op_e op, input logic [13:0] v);
    cmd_valid   = 1'b1;
    cmd_op      = op;
    cmd_operand = v;
    @(negedge clk);
    cmd_valid   = 1'b0;
    cmd_op      = OP_NOP;
    cmd_operand = '0;
  endtask

  task automatic do_read(input bit exp_issue);
    exp_q.push_back(exp_issue);
    send(OP_READ, '0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called just after the edge that started a lock window
  task automatic lock_check(input string req);
    bit early = 0;
    for (int i = 0; i < LOCK; i++) begin
      if (read_ok) early = 1;
      @(negedge clk);
    end
    chk(!early, {req, " read_ok low through lock window"}, early, 0);
    chk(read_ok == 1'b1, {req, " read_ok high at end of lock"}, read_ok, 1);
  endtask

  // scoreboard monitor for READ outcomes
  always @(negedge clk) begin
    if (!rst && (read_issue || read_violation)) begin
      if (read_issue && read_violation)
        chk(0, "R5 both pulses", 2, 1);
      else if (exp_q.size() == 0)
        chk(0, "R5 unexpected pulse", read_issue, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(read_issue == e, "R5 read outcome", read_issue, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    bit early;
    idle(4);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk(read_ok == 0, "R1 read_ok", read_ok, 0);
    chk(odt_pin == 0, "R1 odt_pin", odt_pin, 0);
    chk(out_enable == 1 && dqs_n_en == 1, "R1 out_enable/dqs_n_en",
        {out_enable, dqs_n_en}, 3);
    chk(drive_reduced == 0 && rdqs_n_en == 0 && rtt_code == 0, "R1 drive/rdqs/rtt",
        {drive_reduced, rdqs_n_en, rtt_code}, 0);

    do_read(1'b0);                               // R5 refused before lock
    send(OP_DLL_RESET, '0);                      // R4 ignored: DLL disabled
    idle(LOCK + 5);
    chk(read_ok == 0, "R4 DLL reset ignored while disabled", read_ok, 0);

    odt_req = 1'b1;
    send(OP_LOAD_EMR, 14'h0806);                 // DLL on, half drive, 75 ohm, rdqs
    chk(drive_reduced == 1 && out_enable == 1, "R2 drive/out", {drive_reduced, out_enable}, 3);
    chk(dqs_n_en == 1 && rdqs_n_en == 1, "R2 strobes", {dqs_n_en, rdqs_n_en}, 3);
    chk(rtt_code == 2'd1, "R3 75 ohm code", rtt_code, 1);
    early = 0;
    for (int i = 0; i < OWAIT; i++) begin
      if (odt_pin) early = 1;
      @(negedge clk);
    end
    chk(!early, "R8 odt held low after enable", early, 0);
    chk(odt_pin == 1, "R8 odt follows request after wait", odt_pin, 1);

    send(OP_DLL_RESET, '0);
    lock_check("R4");
    do_read(1'b1);                               // R5 issued

    send(OP_LOAD_EMR, 14'h0040);
    chk(rtt_code == 2'd2, "R3 150 ohm code", rtt_code, 2);
    chk(rdqs_n_en == 0, "R2 rdqs_n off", rdqs_n_en, 0);
    send(OP_LOAD_EMR, 14'h0044);
    chk(rtt_code == 2'd3, "R3 50 ohm code", rtt_code, 3);
    send(OP_LOAD_EMR, 14'h1000);
    chk(out_enable == 0 && rtt_code == 0, "R2/R3 outputs off, term off",
        {out_enable, rtt_code}, 0);
    idle(OWAIT + 2);
    chk(odt_pin == 0, "R9 odt low with term off", odt_pin, 0);
    send(OP_LOAD_EMR, 14'h0C00);
    chk(dqs_n_en == 0 && rdqs_n_en == 0, "R2 single-ended strobe", {dqs_n_en, rdqs_n_en}, 0);
    chk(read_ok == 1, "R6 read_ok kept with DLL on", read_ok, 1);

    send(OP_LOAD_EMR, 14'h0004);
    idle(OWAIT + 1);
    chk(odt_pin == 1, "R8 odt high with term on", odt_pin, 1);
    send(OP_SR_ENTER, '0);
    chk(odt_pin == 0 && read_ok == 0, "R7 self refresh entry", {odt_pin, read_ok}, 0);
    idle(3);
    chk(odt_pin == 0, "R9 odt low in self refresh", odt_pin, 0);
    do_read(1'b0);
    send(OP_SR_EXIT, '0);
    lock_check("R7");
    chk(odt_pin == 1, "R9 odt back after exit", odt_pin, 1);

    send(OP_LOAD_EMR, 14'h0005);
    chk(read_ok == 0, "R6 DLL disable clears read_ok", read_ok, 0);
    send(OP_DLL_RESET, '0);
    idle(LOCK + 5);
    chk(read_ok == 0, "R4 DLL reset ignored after disable", read_ok, 0);
    do_read(1'b0);
    idle(3);
    chk(exp_q.size() == 0, "R5 all reads answered", exp_q.size(), 0);
    finish_run();
  end

endmodule